// File: doc/BRIEF.md
# Byte-Serial Multi-Precision Execution Sequencer

This block carries out one 8-bit instruction over an 8-bit datapath. It handles operands wider than one byte by holding a single execute state for as many clock cycles as the operand has bytes, instead of running a loop in microcode. Each execute cycle reads one byte from the register store and one from memory, combines them, writes at most one result byte, and pulses a decrement strobe. An external address unit uses that strobe to step both address counters to the next byte. Bytes arrive least significant first. A carry or borrow is passed from each byte to the next. The condition flags change once, at the end of the instruction.

Instructions arrive on a valid/ready stream. `ins_ready` is high only while the sequencer is idle. An instruction is taken on a clock edge where `ins_valid` and `ins_ready` are both high. While an instruction executes, `ins_ready` stays low, and the sender must hold its next instruction until ready returns. The register and memory ports are plain: reads are combinational from the current byte address, and a write happens on the edge where its enable is high. A one-cycle `done` pulse marks the end of every instruction.

Top module: `seq_serial_exec`

## Requirements
- R1: An instruction byte is decoded as opcode = bits 7:4, index field = bits 3:2 (driven on `mem_idx`) and operand register = bits 1:0 (driven on `rf_sel`, where 0 = accumulator and 1..3 = the three address registers). Both selects hold their values for the whole execution.
- R2: `ins_ready` is 1 exactly when the sequencer is idle. While `busy` is 1, no instruction is accepted.
- R3: An instruction whose operand register is the accumulator runs for the current length setting, which can be 1 to 8 bytes. Opcode 0xB (set-length) loads a length of bits 2:0 + 1. That setting stays in force until the next set-length instruction. After reset the length is 1 byte.
- R4: An instruction on any operand register other than the accumulator runs for exactly 2 bytes, whatever the length setting.
- R5: Opcode 0xA (count) adds 1 to a memory operand of exactly one byte and writes it back. It updates C and Z.
- R6: The arithmetic opcodes all chain carry between bytes, starting with a carry-in of 0:
  - Opcode 0 writes reg+mem to the register.
  - Opcode 6 writes reg+mem to memory.
  - Opcode 0xC writes reg+reg to the register, which is a one-bit left shift.
- R7: Opcode 7 writes reg−mem to the register. Opcode 8 computes the same difference but writes nothing. The subtraction is done as reg + ~mem with a first carry-in of 1, so C=1 means no borrow.
- R8: The logical opcodes are:
  - Opcode 2 loads memory into the register.
  - Opcode 3 writes XOR to the register.
  - Opcode 4 writes AND to the register.
  - Opcode 5 computes the AND but writes nothing.

  All four clear C.
- R9: Opcode 1 stores the register into memory and leaves both flags unchanged.
- R10: `addr_dec` pulses exactly once for each processed byte. At most one of `rf_we` and `mem_we` is high in any cycle, and only in that byte's cycle.
- R11: Z=1 when every result byte of the instruction is zero. C is the carry out of the final, most significant byte. The flags do not change while bytes are being processed.
- R12: `done` pulses for one cycle after the last byte. Set-length and the opcodes 9, 0xD, 0xE and 0xF pulse `done` in the cycle after acceptance, with no byte cycles, no writes and no change to the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction byte present |
| ins_ready | output | 1 | Sequencer idle, instruction will be taken |
| ins_byte | input | 8 | Instruction byte |
| busy | output | 1 | Byte cycles in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |
| rf_sel | output | 2 | Operand register select |
| rf_rdata | input | 8 | Register store byte at current address |
| rf_wdata | output | 8 | Result byte for register store |
| rf_we | output | 1 | Register store write enable |
| mem_idx | output | 2 | Index register select for the address unit |
| mem_rdata | input | 8 | Memory byte at current address |
| mem_wdata | output | 8 | Result byte for memory |
| mem_we | output | 1 | Memory write enable |
| addr_dec | output | 1 | Decrement strobe for both address counters |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench sets each length from 1 to 8. At each length it runs every data opcode on the accumulator and on the address registers, over operands chosen to stress the carry chain. These include all-ones plus one, equal operands, zeros and pseudo-random values. The model compares all eight stored bytes, so it catches the following faults:
- a carry not passed between bytes, which corrupts the upper bytes;
- a wrong first carry-in for subtraction, which gives results off by one;
- a length that leaks into the fixed-length registers, which changes the pulse count;
- a write by compare, test or count that spills beyond its bytes.

Z built from only the last byte would fail on operands with a nonzero low byte and a zero high byte. A set-length, store or undefined opcode that disturbed the flags would show up as a flag mismatch on the next check.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int INS_W = 8;
  localparam int OPC_W = 4;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] REG_ACC = '0;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 4'h0,
    OP_STO  = 4'h1,
    OP_LOAD = 4'h2,
    OP_XOR  = 4'h3,
    OP_AND  = 4'h4,
    OP_TEST = 4'h5,
    OP_ADDM = 4'h6,
    OP_SUB  = 4'h7,
    OP_CMP  = 4'h8,
    OP_RSV9 = 4'h9,
    OP_CNT  = 4'hA,
    OP_SETL = 4'hB,
    OP_SHL  = 4'hC,
    OP_RSVD = 4'hD,
    OP_RSVE = 4'hE,
    OP_RSVF = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    FN_ADD,
    FN_XOR,
    FN_AND,
    FN_PASS_A,
    FN_PASS_B
  } alu_fn_e;

  typedef enum logic [1:0] {
    BS_MEM,
    BS_REG,
    BS_ZERO
  } bsrc_e;

  typedef struct packed {
    logic    run;        // has byte cycles
    logic    is_set;     // length load
    logic    a_mem;      // A operand from memory
    bsrc_e   b_src;
    logic    inv_b;
    logic    cin;        // first-byte carry in
    alu_fn_e fn;
    logic    wr_reg;
    logic    wr_mem;
    logic    upd_flags;
    logic    arith;      // carry flag from adder
    logic    single;     // one byte regardless of length
  } ctrl_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  opcode_e op,
  output ctrl_t   ctl
);

  always_comb begin
    ctl           = '0;
    ctl.b_src     = BS_MEM;
    ctl.fn        = FN_ADD;
    unique case (op)
      OP_ADD: begin
        ctl.run = 1'b1; ctl.wr_reg = 1'b1; ctl.upd_flags = 1'b1; ctl.arith = 1'b1;
      end
      OP_STO: begin
        ctl.run = 1'b1; ctl.fn = FN_PASS_A; ctl.wr_mem = 1'b1;
      end
      OP_LOAD: begin
        ctl.run = 1'b1; ctl.fn = FN_PASS_B; ctl.wr_reg = 1'b1; ctl.upd_flags = 1'b1;
      end
      OP_XOR: begin
        ctl.run = 1'b1; ctl.fn = FN_XOR; ctl.wr_reg = 1'b1; ctl.upd_flags = 1'b1;
      end
      OP_AND: begin
        ctl.run = 1'b1; ctl.fn = FN_AND; ctl.wr_reg = 1'b1; ctl.upd_flags = 1'b1;
      end
      OP_TEST: begin
        ctl.run = 1'b1; ctl.fn = FN_AND; ctl.upd_flags = 1'b1;
      end
      OP_ADDM: begin
        ctl.run = 1'b1; ctl.wr_mem = 1'b1; ctl.upd_flags = 1'b1; ctl.arith = 1'b1;
      end
      OP_SUB: begin
        ctl.run = 1'b1; ctl.inv_b = 1'b1; ctl.cin = 1'b1; ctl.wr_reg = 1'b1;
        ctl.upd_flags = 1'b1; ctl.arith = 1'b1;
      end
      OP_CMP: begin
        ctl.run = 1'b1; ctl.inv_b = 1'b1; ctl.cin = 1'b1;
        ctl.upd_flags = 1'b1; ctl.arith = 1'b1;
      end
      OP_CNT: begin
        ctl.run = 1'b1; ctl.a_mem = 1'b1; ctl.b_src = BS_ZERO; ctl.cin = 1'b1;
        ctl.wr_mem = 1'b1; ctl.upd_flags = 1'b1; ctl.arith = 1'b1; ctl.single = 1'b1;
      end
      OP_SETL: begin
        ctl.is_set = 1'b1;
      end
      OP_SHL: begin
        ctl.run = 1'b1; ctl.b_src = BS_REG; ctl.wr_reg = 1'b1;
        ctl.upd_flags = 1'b1; ctl.arith = 1'b1;
      end
      default: begin
        ctl.run = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/seq_byte_alu.sv
module seq_byte_alu
  import seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  alu_fn_e           fn,
  output logic [DATA_W-1:0] y,
  output logic              cout,
  output logic              zero
);

  logic [DATA_W:0] sum;

  assign sum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};

  always_comb begin
    y    = '0;
    cout = 1'b0;
    unique case (fn)
      FN_ADD: begin
        y    = sum[DATA_W-1:0];
        cout = sum[DATA_W];
      end
      FN_XOR:    y = a ^ b;
      FN_AND:    y = a & b;
      FN_PASS_A: y = a;
      FN_PASS_B: y = b;
      default:   y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/seq_len_count.sv
module seq_len_count #(
  parameter int MAX_LEN   = 8,
  parameter int FIXED_LEN = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_len,
  input  logic [$clog2(MAX_LEN)-1:0] set_val,
  input  logic                       start,
  input  logic                       start_acc,
  input  logic                       start_single,
  input  logic                       step,
  output logic                       last
);

  localparam int LEN_W = $clog2(MAX_LEN);
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic [LEN_W-1:0] len_q;   // length minus one, sticky
  logic [CNT_W-1:0] cnt_q;   // bytes remaining including current
  logic [CNT_W-1:0] cnt_init;

  always_comb begin
    if (start_single)   cnt_init = CNT_W'(1);
    else if (start_acc) cnt_init = CNT_W'(len_q) + CNT_W'(1);
    else                cnt_init = CNT_W'(FIXED_LEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      if (set_len) len_q <= set_val;
      if (start)           cnt_q <= cnt_init;
      else if (step && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/seq_serial_exec.sv
module seq_serial_exec
  import seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_LEN   = 8,
  parameter int FIXED_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [INS_W-1:0]  ins_byte,
  output logic              busy,
  output logic              done,
  output logic [SEL_W-1:0]  rf_sel,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic [SEL_W-1:0]  mem_idx,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              addr_dec,
  output logic              flag_c,
  output logic              flag_z
);

  localparam int LEN_W = $clog2(MAX_LEN);

  typedef enum logic {ST_IDLE, ST_EXEC} state_e;

  state_e            state_q;
  ctrl_t             ctl_d, ctl_q;
  opcode_e           op_d;
  logic [SEL_W-1:0]  sel_q, idx_q;
  logic              carry_q, zacc_q, done_q, fc_q, fz_q;
  logic              accept, executing, last_byte;
  logic [DATA_W-1:0] opa, b_raw, opb, alu_y;
  logic              alu_c, alu_z;

  assign op_d      = opcode_e'(ins_byte[INS_W-1 -: OPC_W]);
  assign executing = (state_q == ST_EXEC);
  assign ins_ready = (state_q == ST_IDLE);
  assign accept    = ins_valid && ins_ready;

  seq_decode u_dec (
    .op  (op_d),
    .ctl (ctl_d)
  );

  seq_len_count #(
    .MAX_LEN   (MAX_LEN),
    .FIXED_LEN (FIXED_LEN)
  ) u_len (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_len      (accept && ctl_d.is_set),
    .set_val      (ins_byte[LEN_W-1:0]),
    .start        (accept && ctl_d.run),
    .start_acc    (ins_byte[SEL_W-1:0] == REG_ACC),
    .start_single (ctl_d.single),
    .step         (executing),
    .last         (last_byte)
  );

  // operand steering
  assign opa = ctl_q.a_mem ? mem_rdata : rf_rdata;

  always_comb begin
    unique case (ctl_q.b_src)
      BS_MEM:  b_raw = mem_rdata;
      BS_REG:  b_raw = rf_rdata;
      default: b_raw = '0;
    endcase
  end

  assign opb = ctl_q.inv_b ? ~b_raw : b_raw;

  seq_byte_alu #(.DATA_W(DATA_W)) u_alu (
    .a    (opa),
    .b    (opb),
    .cin  (carry_q),
    .fn   (ctl_q.fn),
    .y    (alu_y),
    .cout (alu_c),
    .zero (alu_z)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
      sel_q   <= '0;
      idx_q   <= '0;
      carry_q <= 1'b0;
      zacc_q  <= 1'b1;
      done_q  <= 1'b0;
      fc_q    <= 1'b0;
      fz_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        ctl_q   <= ctl_d;
        sel_q   <= ins_byte[SEL_W-1:0];
        idx_q   <= ins_byte[2*SEL_W-1:SEL_W];
        carry_q <= ctl_d.cin;
        zacc_q  <= 1'b1;
        if (ctl_d.run) state_q <= ST_EXEC;
        else           done_q  <= 1'b1;
      end else if (executing) begin
        carry_q <= alu_c;
        zacc_q  <= zacc_q & alu_z;
        if (last_byte) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          if (ctl_q.upd_flags) begin
            fz_q <= zacc_q & alu_z;
            fc_q <= ctl_q.arith ? alu_c : 1'b0;
          end
        end
      end
    end
  end

  assign busy      = executing;
  assign done      = done_q;
  assign rf_sel    = sel_q;
  assign mem_idx   = idx_q;
  assign rf_wdata  = alu_y;
  assign mem_wdata = alu_y;
  assign rf_we     = executing && ctl_q.wr_reg;
  assign mem_we    = executing && ctl_q.wr_mem;
  assign addr_dec  = executing;
  assign flag_c    = fc_q;
  assign flag_z    = fz_q;

endmodule

// File: rtl/seq_serial_exec_chk.sv
module seq_serial_exec_chk #(
  parameter int MAX_LEN = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ins_valid,
  input logic       ins_ready,
  input logic [7:0] ins_byte,
  input logic       busy,
  input logic       done,
  input logic [1:0] rf_sel,
  input logic       rf_we,
  input logic [1:0] mem_idx,
  input logic       mem_we,
  input logic       addr_dec,
  input logic       flag_c,
  input logic       flag_z
);

  localparam int RUN_W = $clog2(MAX_LEN + 1) + 1;

  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + RUN_W'(1);
    else           run_cnt <= '0;
  end

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ins_ready);

  assert_dec_in_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_dec |-> busy);

  assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && mem_we));

  assert_done_after_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(flag_c) && $stable(flag_z)));

  assert_select_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(rf_sel) && $stable(mem_idx)));

  assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_W'(MAX_LEN));

endmodule

bind seq_serial_exec seq_serial_exec_chk #(.MAX_LEN(MAX_LEN)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .ins_byte  (ins_byte),
  .busy      (busy),
  .done      (done),
  .rf_sel    (rf_sel),
  .rf_we     (rf_we),
  .mem_idx   (mem_idx),
  .mem_we    (mem_we),
  .addr_dec  (addr_dec),
  .flag_c    (flag_c),
  .flag_z    (flag_z)
);

// File: tb/test_seq_serial_exec.sv
module test_seq_serial_exec;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ins_valid = 1'b0;
  logic       ins_ready;
  logic [7:0] ins_byte = 8'h00;
  logic       busy, done;
  logic [1:0] rf_sel, mem_idx;
  logic [7:0] rf_rdata, rf_wdata, mem_rdata, mem_wdata;
  logic       rf_we, mem_we, addr_dec, flag_c, flag_z;

  always #4 clk = ~clk;   // 125 MHz

  seq_serial_exec i_seq_serial_exec (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_byte(ins_byte), .busy(busy), .done(done), .rf_sel(rf_sel),
    .rf_rdata(rf_rdata), .rf_wdata(rf_wdata), .rf_we(rf_we), .mem_idx(mem_idx),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .addr_dec(addr_dec), .flag_c(flag_c), .flag_z(flag_z)
  );

  // register store and memory operand, byte 0 = least significant
  logic [7:0] regs [4][8];
  logic [7:0] mops [8];
  logic [2:0] ri, mi;

  assign rf_rdata  = regs[rf_sel][ri];
  assign mem_rdata = mops[mi];

  always @(posedge clk) begin
    if (rf_we)  regs[rf_sel][ri] <= rf_wdata;
    if (mem_we) mops[mi] <= mem_wdata;
    if (addr_dec) begin
      ri <= ri + 3'd1;
      mi <= mi + 3'd1;
    end
  end

  int   nchk = 0;
  int   nerr = 0;
  logic exp_c = 1'b0, exp_z = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd(input logic [63:0] s);
    logic [63:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  function automatic logic [63:0] reg_val(input int r);
    logic [63:0] v = '0;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = regs[r][k];
    return v;
  endfunction

  function automatic logic [63:0] mem_val();
    logic [63:0] v = '0;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = mops[k];
    return v;
  endfunction

  task automatic load(input int r, input logic [63:0] rv, input logic [63:0] mv);
    for (int k = 0; k < 8; k++) begin
      regs[r][k] = rv[8*k +: 8];
      mops[k]    = mv[8*k +: 8];
    end
  endtask

  // issue one instruction, return number of byte strobes
  task automatic issue(input logic [7:0] ins, output int ndec);
    int  cyc = 0;
    bit  rdy_bad = 0, sel_bad = 0;
    @(negedge clk);
    ri = 3'd0; mi = 3'd0;
    ins_byte  = ins;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    ndec = 0;
    while (!done && cyc < 40) begin
      if (busy) begin
        if (ins_ready) rdy_bad = 1;
        if (rf_sel != ins[1:0] || mem_idx != ins[3:2]) sel_bad = 1;
      end
      if (addr_dec) ndec++;
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, "R12 done pulse", {63'd0, done}, 64'd1);
    chk(!rdy_bad, "R2 ready low while busy", {63'd0, rdy_bad}, 64'd0);
    chk(!sel_bad, "R1 selects follow fields", {63'd0, sel_bad}, 64'd0);
  endtask

  // arithmetic model of one data instruction
  task automatic model(input int op, input logic [63:0] af, input logic [63:0] bf, input int n,
                       output logic [63:0] er, output logic [63:0] em,
                       output logic ec, output logic ez, output bit fl);
    logic [63:0] mask, a, b, res;
    logic [71:0] s;
    mask = (n == 8) ? {64{1'b1}} : ((64'd1 << (8*n)) - 64'd1);
    a = af & mask; b = bf & mask;
    er = af; em = bf; fl = 1; ec = 0; s = '0; res = '0;
    case (op)
      0:  begin s = {8'd0, a} + {8'd0, b}; res = s[63:0] & mask; er = (af & ~mask) | res; ec = s[8*n]; end
      1:  begin em = (bf & ~mask) | a; fl = 0; end
      2:  begin res = b; er = (af & ~mask) | res; end
      3:  begin res = a ^ b; er = (af & ~mask) | res; end
      4:  begin res = a & b; er = (af & ~mask) | res; end
      5:  begin res = a & b; end
      6:  begin s = {8'd0, a} + {8'd0, b}; res = s[63:0] & mask; em = (bf & ~mask) | res; ec = s[8*n]; end
      7:  begin s = {8'd0, a} + {8'd0, (~b) & mask} + 72'd1; res = s[63:0] & mask; er = (af & ~mask) | res; ec = s[8*n]; end
      8:  begin s = {8'd0, a} + {8'd0, (~b) & mask} + 72'd1; res = s[63:0] & mask; ec = s[8*n]; end
      10: begin s = {8'd0, b} + 72'd1; res = s[63:0] & mask; em = (bf & ~mask) | res; ec = s[8*n]; end
      12: begin s = {8'd0, a} + {8'd0, a}; res = s[63:0] & mask; er = (af & ~mask) | res; ec = s[8*n]; end
      default: fl = 0;
    endcase
    ez = (res == '0);
  endtask

  function automatic string op_req(input int op);
    case (op)
      0, 6, 12: return "R6";
      7, 8:     return "R7";
      1:        return "R9";
      10:       return "R5";
      default:  return "R8";
    endcase
  endfunction

  task automatic run_op(input int op, input int r, input int idx, input int n,
                        input logic [63:0] av, input logic [63:0] bv, input string lenreq);
    logic [63:0] er, em;
    logic ec, ez;
    bit fl;
    int nd;
    string rq;
    rq = op_req(op);
    load(r, av, bv);
    model(op, av, bv, n, er, em, ec, ez, fl);
    if (fl) begin exp_c = ec; exp_z = ez; end
    issue({op[3:0], idx[1:0], r[1:0]}, nd);
    chk(nd == n, {lenreq, " R10 byte count"}, 64'(nd), 64'(n));
    chk(reg_val(r) == er, {rq, " register result"}, reg_val(r), er);
    chk(mem_val() == em, {rq, " memory result"}, mem_val(), em);
    chk(flag_c == exp_c, {rq, " R11 carry flag"}, {63'd0, flag_c}, {63'd0, exp_c});
    chk(flag_z == exp_z, {rq, " R11 zero flag"}, {63'd0, flag_z}, {63'd0, exp_z});
  endtask

  int ops[10] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 12};

  initial begin
    int nd;
    logic [63:0] av, bv, r_before, m_before;
    for (int r = 0; r < 4; r++) load(r, 64'h0, 64'h0);
    ri = 3'd0; mi = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(ins_ready && !busy && !done, "R2 idle after reset", {61'd0, ins_ready, busy, done}, 64'h4);
    chk(!flag_c && !flag_z, "R11 flags clear after reset", {62'd0, flag_c, flag_z}, 64'd0);
    chk(!addr_dec && !rf_we && !mem_we, "R10 no strobes after reset", {61'd0, addr_dec, rf_we, mem_we}, 64'd0);

    // R3: default length is one byte
    run_op(0, 0, 1, 1, 64'h1122_3344_5566_77FF, 64'h0102_0304_0506_0702, "R3");

    for (int len = 1; len <= 8; len++) begin
      logic pc, pz;
      pc = flag_c; pz = flag_z;
      issue(8'hB0 | 8'(len - 1), nd);
      chk(nd == 0, "R12 set-length has no byte cycles", 64'(nd), 64'd0);
      chk(flag_c == pc && flag_z == pz, "R3 set-length keeps flags", {62'd0, flag_c, flag_z}, {62'd0, pc, pz});
      for (int pat = 0; pat < 5; pat++) begin
        for (int oi = 0; oi < 10; oi++) begin
          seed = rnd(seed); av = seed;
          seed = rnd(seed); bv = seed;
          case (pat)
            1: bv = av;
            2: begin av = {64{1'b1}}; bv = 64'd1; end
            3: begin av = 64'd0; bv = 64'd0; end
            4: begin av = {av[63:8], 8'h00}; bv = {bv[63:8], 8'h00}; end
            default: ;
          endcase
          run_op(ops[oi], 0, pat % 4, len, av, bv, "R3");
          run_op(ops[oi], 1 + (pat % 3), (pat + 1) % 4, 2, bv, av, "R4");
        end
      end
    end

    // R5: count is one byte whatever the length (length is now 8)
    run_op(10, 0, 2, 1, 64'h0, 64'h55AA_55AA_55AA_55FF, "R5");
    run_op(10, 0, 3, 1, 64'h0, 64'hFFFF_FFFF_FFFF_FF7F, "R5");
    run_op(10, 2, 0, 1, 64'h0, 64'h0000_0000_0000_0000, "R5");

    // R12: undefined opcodes do nothing
    for (int u = 0; u < 4; u++) begin
      logic [3:0] opc;
      logic pc, pz;
      opc = (u == 0) ? 4'h9 : 4'(12 + u);
      load(0, 64'hDEAD_BEEF_0BAD_F00D, 64'h0123_4567_89AB_CDEF);
      r_before = reg_val(0); m_before = mem_val();
      pc = flag_c; pz = flag_z;
      issue({opc, 4'h0}, nd);
      chk(nd == 0, "R12 undefined opcode byte count", 64'(nd), 64'd0);
      chk(reg_val(0) == r_before && mem_val() == m_before, "R12 undefined opcode no write",
          reg_val(0) ^ mem_val(), r_before ^ m_before);
      chk(flag_c == pc && flag_z == pz, "R12 undefined opcode flags", {62'd0, flag_c, flag_z}, {62'd0, pc, pz});
    end

    // R3: sticky length survives other instructions
    issue(8'hB2, nd);
    run_op(2, 0, 0, 3, 64'h0, 64'h0000_0000_00AB_CDEF, "R3");
    run_op(3, 0, 1, 3, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_00FF_FFFF, "R3");

    @(negedge clk);
    summary();
  end

endmodule